// File: doc/BRIEF.md
# Scoreboarded Multi-Warp Instruction Issuer

This block sits between a warp instruction fetcher and a shared execution port. It holds at most one waiting instruction for each warp. Each instruction names a destination register, two source registers, an opcode and a long-latency flag. A scoreboard keeps one pending-write bit per warp per register. Every buffered instruction is compared against the scoreboard of its own warp. An instruction becomes eligible only when its destination and both sources are free.

Each cycle the issuer may accept one new instruction into an empty warp slot. When the dispatch port is free and no stall is requested, it also picks one eligible warp. The pick is round-robin: the search starts at the warp after the one that issued most recently. An issue marks the destination register pending and frees the slot. It then holds the dispatch port for four cycles, which is the time needed to broadcast one instruction across a 32-thread warp. Results written back clear pending bits. The clear also counts for the selection made in that same cycle, so a waiting consumer can issue immediately.

Top module: `warp_issue_unit`

## Requirements
- R1: After reset, `issue_valid` and `dispatch_busy` are low, every slot is empty and every pending bit is clear.
- R2: When `fill_valid` is high and the slot of `fill_warp` is empty, the instruction is stored on that clock edge. It can issue on the next edge at the earliest, so it appears on the issue outputs two cycles after being driven.
- R3: A fill aimed at a warp whose slot is already occupied is ignored. The earlier instruction issues unchanged and the ignored one never issues.
- R4: A buffered instruction is eligible only when its own warp has no pending write on its destination register or on either source register. Pending bits of other warps do not affect it.
- R5: On issue, the destination register of the issuing warp is marked pending and the warp's slot becomes empty. That warp can then accept a new instruction.
- R6: A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears the pending bit, and the clear already counts for selection on that same edge. A blocked dependent instruction therefore appears on the issue outputs one cycle after the writeback is driven.
- R7: If a writeback and an issue name the same warp and register on the same edge, the register stays pending.
- R8: Among eligible warps, the first one found searching upward from the warp after the last issued warp (wrapping from 23 to 0) is chosen. After reset the search starts at warp 0.
- R9: An issue holds the dispatch port for 4 cycles. `dispatch_busy` is high for exactly 4 cycles starting with the cycle `issue_valid` is high. When eligible work is waiting, consecutive issues are exactly 4 cycles apart.
- R10: While `stall` is high no instruction issues, but fills are still accepted.
- R11: A warp with an outstanding long-latency result keeps issuing instructions that do not touch the pending register.
- R12: `issue_valid` is a one-cycle pulse for each issue. It comes with the warp number (binary, 0 to 23) and the opcode, destination, sources and long-latency flag of the issued instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Write an instruction into a warp slot |
| fill_warp | input | 5 | Target warp of the fill |
| fill_opcode | input | 8 | Opcode of the filled instruction |
| fill_dst | input | 4 | Destination register |
| fill_src0 | input | 4 | First source register |
| fill_src1 | input | 4 | Second source register |
| fill_long | input | 1 | Long-latency flag |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | 5 | Warp of the written-back result |
| wb_reg | input | 4 | Register of the written-back result |
| stall | input | 1 | Hold off issue |
| issue_valid | output | 1 | One-cycle pulse per issued instruction |
| issue_warp | output | 5 | Issued warp number |
| issue_opcode | output | 8 | Issued opcode |
| issue_dst | output | 4 | Issued destination register |
| issue_src0 | output | 4 | Issued first source |
| issue_src1 | output | 4 | Issued second source |
| issue_long | output | 1 | Issued long-latency flag |
| dispatch_busy | output | 1 | Dispatch port occupied |

## Verification
The bench starts with a single lone instruction, which shows the fill-to-issue latency, the issued fields and the four-cycle busy window. Several warps are then filled at once behind a stall, so releasing the stall shows the round-robin order and the exact four-cycle spacing between issues. Dependent chains within one warp separate the read-after-write and write-after-write blocking from independent progress under an outstanding long-latency load. A writeback to a different warp with the same register number shows that the scoreboard is per warp, and a writeback coinciding with an issue shows that the set wins. Refilling an already occupied slot shows the fill is dropped.

// File: rtl/wiss_pkg.sv
package wiss_pkg;

    localparam int unsigned NUM_WARPS       = 24;
    localparam int unsigned NUM_REGS        = 16;
    localparam int unsigned DISPATCH_CYCLES = 4;
    localparam int unsigned OPC_W           = 8;

    localparam int unsigned WARP_W = $clog2(NUM_WARPS);
    localparam int unsigned REG_W  = $clog2(NUM_REGS);
    localparam int unsigned CNT_W  = $clog2(DISPATCH_CYCLES + 1);

    typedef logic [WARP_W-1:0] warp_id_t;
    typedef logic [REG_W-1:0]  reg_id_t;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        reg_id_t          dst;
        reg_id_t          src0;
        reg_id_t          src1;
        logic             long_lat;
    } winstr_t;

    typedef logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_map_t;

    function automatic logic hazard_free(input winstr_t ins,
                                         input logic [NUM_REGS-1:0] pend);
        return !pend[ins.dst] && !pend[ins.src0] && !pend[ins.src1];
    endfunction

endpackage

// File: rtl/wiss_scoreboard.sv
module wiss_scoreboard
    import wiss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      set_en,
    input  warp_id_t  set_warp,
    input  reg_id_t   set_reg,
    input  logic      clr_en,
    input  warp_id_t  clr_warp,
    input  reg_id_t   clr_reg,
    output pend_map_t pend_eff
);

    pend_map_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            if (clr_en && (int'(clr_warp) < NUM_WARPS))
                pend_q[clr_warp][clr_reg] <= 1'b0;
            if (set_en)
                pend_q[set_warp][set_reg] <= 1'b1;
        end
    end

    // Writeback clear bypasses into this cycle's selection.
    always_comb begin
        pend_eff = pend_q;
        if (clr_en && (int'(clr_warp) < NUM_WARPS))
            pend_eff[clr_warp][clr_reg] = 1'b0;
    end

    // R7
    sb_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> pend_q[$past(set_warp)][$past(set_reg)]);

    // R6
    sb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && (int'(clr_warp) < NUM_WARPS) &&
         !(set_en && set_warp == clr_warp && set_reg == clr_reg))
        |=> !pend_q[$past(clr_warp)][$past(clr_reg)]);

endmodule

// File: rtl/wiss_ibuf.sv
module wiss_ibuf
    import wiss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fill_en,
    input  warp_id_t             fill_warp,
    input  winstr_t              fill_instr,
    input  logic                 free_en,
    input  warp_id_t             free_warp,
    input  pend_map_t            pend_eff,
    output winstr_t              slot_q [NUM_WARPS],
    output logic [NUM_WARPS-1:0] ready
);

    logic [NUM_WARPS-1:0] valid_q;
    logic                 fill_ok;

    assign fill_ok = fill_en && (int'(fill_warp) < NUM_WARPS) && !valid_q[fill_warp];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (fill_ok)
                valid_q[fill_warp] <= 1'b1;
            if (free_en)
                valid_q[free_warp] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_ok)
            slot_q[fill_warp] <= fill_instr;
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ready
        assign ready[w] = valid_q[w] && hazard_free(slot_q[w], pend_eff[w]);
    end

    // R3
    ibuf_fill_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && (int'(fill_warp) < NUM_WARPS) && valid_q[fill_warp])
        |=> slot_q[$past(fill_warp)] == $past(slot_q[fill_warp]));

    // R5
    ibuf_free_chk: assert property (@(posedge clk) disable iff (rst)
        free_en |=> !valid_q[$past(free_warp)]);

endmodule

// File: rtl/wiss_rr_pick.sv
module wiss_rr_pick
    import wiss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] req,
    input  logic                 advance,
    output logic                 gnt_valid,
    output warp_id_t             gnt_idx
);

    warp_id_t last_q;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= warp_id_t'(NUM_WARPS - 1);
        else if (advance)
            last_q <= gnt_idx;
    end

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 1; i <= NUM_WARPS; i++) begin
            int c;
            c = int'(last_q) + i;
            if (c >= NUM_WARPS)
                c = c - NUM_WARPS;
            if (!gnt_valid && req[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = warp_id_t'(c);
            end
        end
    end

    // R8
    rr_grant_req_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_idx]);

    // R8
    rr_no_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> gnt_valid);

endmodule

// File: rtl/wiss_dispatch_timer.sv
module wiss_dispatch_timer
    import wiss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic port_free,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(DISPATCH_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy      = (cnt_q != '0);
    assign port_free = (cnt_q <= CNT_W'(1));

    // R9
    timer_start_free_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> port_free);

    // R9
    timer_busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/warp_issue_unit.sv
module warp_issue_unit
    import wiss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_valid,
    input  logic [WARP_W-1:0] fill_warp,
    input  logic [OPC_W-1:0]  fill_opcode,
    input  logic [REG_W-1:0]  fill_dst,
    input  logic [REG_W-1:0]  fill_src0,
    input  logic [REG_W-1:0]  fill_src1,
    input  logic              fill_long,
    input  logic              wb_valid,
    input  logic [WARP_W-1:0] wb_warp,
    input  logic [REG_W-1:0]  wb_reg,
    input  logic              stall,
    output logic              issue_valid,
    output logic [WARP_W-1:0] issue_warp,
    output logic [OPC_W-1:0]  issue_opcode,
    output logic [REG_W-1:0]  issue_dst,
    output logic [REG_W-1:0]  issue_src0,
    output logic [REG_W-1:0]  issue_src1,
    output logic              issue_long,
    output logic              dispatch_busy
);

    winstr_t              fill_instr;
    winstr_t              slots [NUM_WARPS];
    winstr_t              pick_instr;
    winstr_t              issue_q;
    pend_map_t            pend_eff;
    logic [NUM_WARPS-1:0] ready;
    logic                 gnt_valid;
    warp_id_t             gnt_idx;
    logic                 port_free;
    logic                 issue_go;

    assign fill_instr = '{opcode: fill_opcode, dst: fill_dst, src0: fill_src0,
                          src1: fill_src1, long_lat: fill_long};

    assign pick_instr = slots[gnt_idx];
    assign issue_go   = gnt_valid && port_free && !stall;

    wiss_scoreboard u_sb (
        .clk      (clk),
        .rst      (rst),
        .set_en   (issue_go),
        .set_warp (gnt_idx),
        .set_reg  (pick_instr.dst),
        .clr_en   (wb_valid),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .pend_eff (pend_eff)
    );

    wiss_ibuf u_buf (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_valid),
        .fill_warp  (fill_warp),
        .fill_instr (fill_instr),
        .free_en    (issue_go),
        .free_warp  (gnt_idx),
        .pend_eff   (pend_eff),
        .slot_q     (slots),
        .ready      (ready)
    );

    wiss_rr_pick u_pick (
        .clk       (clk),
        .rst       (rst),
        .req       (ready),
        .advance   (issue_go),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    wiss_dispatch_timer u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (issue_go),
        .port_free (port_free),
        .busy      (dispatch_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_q     <= '0;
        end else begin
            issue_valid <= issue_go;
            if (issue_go) begin
                issue_warp <= gnt_idx;
                issue_q    <= pick_instr;
            end
        end
    end

    assign issue_opcode = issue_q.opcode;
    assign issue_dst    = issue_q.dst;
    assign issue_src0   = issue_q.src0;
    assign issue_src1   = issue_q.src1;
    assign issue_long   = issue_q.long_lat;

    // R9
    issue_gap_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !issue_valid);

    // R9
    issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> dispatch_busy);

    // R10
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !issue_valid);

    // R12
    issue_warp_range_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (int'(issue_warp) < NUM_WARPS));

endmodule

// File: tb/tb_warp_issue_unit.sv
module tb_warp_issue_unit;
    import wiss_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fill_valid = 1'b0;
    logic [WARP_W-1:0] fill_warp = '0;
    logic [OPC_W-1:0]  fill_opcode = '0;
    logic [REG_W-1:0]  fill_dst = '0;
    logic [REG_W-1:0]  fill_src0 = '0;
    logic [REG_W-1:0]  fill_src1 = '0;
    logic              fill_long = 1'b0;
    logic              wb_valid = 1'b0;
    logic [WARP_W-1:0] wb_warp = '0;
    logic [REG_W-1:0]  wb_reg = '0;
    logic              stall = 1'b0;
    logic              issue_valid;
    logic [WARP_W-1:0] issue_warp;
    logic [OPC_W-1:0]  issue_opcode;
    logic [REG_W-1:0]  issue_dst;
    logic [REG_W-1:0]  issue_src0;
    logic [REG_W-1:0]  issue_src1;
    logic              issue_long;
    logic              dispatch_busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_iss = 0;
    int log_warp [64];
    int log_op   [64];
    int log_dst  [64];
    int log_cyc  [64];

    warp_issue_unit dut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && issue_valid) begin
            if (n_iss < 64) begin
                log_warp[n_iss] = int'(issue_warp);
                log_op[n_iss]   = int'(issue_opcode);
                log_dst[n_iss]  = int'(issue_dst);
                log_cyc[n_iss]  = cyc;
            end
            n_iss = n_iss + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill_one(input int w, input int op, input int d,
                            input int s0, input int s1, input bit lng);
        fill_valid  = 1'b1;
        fill_warp   = WARP_W'(w);
        fill_opcode = OPC_W'(op);
        fill_dst    = REG_W'(d);
        fill_src0   = REG_W'(s0);
        fill_src1   = REG_W'(s1);
        fill_long   = lng;
        @(negedge clk);
        fill_valid  = 1'b0;
    endtask

    task automatic wb_one(input int w, input int r);
        wb_valid = 1'b1;
        wb_warp  = WARP_W'(w);
        wb_reg   = REG_W'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic t_reset();
        int base;
        base = n_iss;
        check(issue_valid == 1'b0, "R1 issue_valid after reset", int'(issue_valid), 0);
        check(dispatch_busy == 1'b0, "R1 busy after reset", int'(dispatch_busy), 0);
        idle(5);
        check(n_iss == base, "R1 no issue from empty slots", n_iss - base, 0);
    endtask

    task automatic t_single();
        int base, k, nb;
        base = n_iss;
        k = cyc;
        fill_one(3, 8'h5a, 5, 1, 2, 1'b0);
        nb = 0;
        repeat (10) begin
            @(negedge clk);
            if (dispatch_busy) nb++;
        end
        check(n_iss == base + 1, "R12 one pulse per issue", n_iss - base, 1);
        check(log_cyc[base] == k + 2, "R2 fill-to-issue latency", log_cyc[base] - k, 2);
        check(log_warp[base] == 3, "R12 issued warp", log_warp[base], 3);
        check(log_op[base] == 8'h5a && log_dst[base] == 5, "R12 issued opcode",
              log_op[base], 8'h5a);
        check(nb == 4, "R9 busy length", nb, 4);
        wb_one(3, 5);
    endtask

    task automatic t_round_robin();
        int base;
        base = n_iss;
        stall = 1'b1;
        fill_one(0, 1, 4, 1, 2, 1'b0);
        fill_one(5, 2, 4, 1, 2, 1'b0);
        fill_one(9, 3, 4, 1, 2, 1'b0);
        idle(4);
        check(n_iss == base, "R10 no issue while stalled", n_iss - base, 0);
        stall = 1'b0;
        idle(20);
        check(n_iss == base + 3, "R10 fills kept during stall", n_iss - base, 3);
        check(log_warp[base] == 5, "R8 first after last issued", log_warp[base], 5);
        check(log_warp[base+1] == 9, "R8 second", log_warp[base+1], 9);
        check(log_warp[base+2] == 0, "R8 wrap to warp 0", log_warp[base+2], 0);
        check(log_cyc[base+1] - log_cyc[base] == 4, "R9 spacing 1",
              log_cyc[base+1] - log_cyc[base], 4);
        check(log_cyc[base+2] - log_cyc[base+1] == 4, "R9 spacing 2",
              log_cyc[base+2] - log_cyc[base+1], 4);
        wb_one(0, 4);
        wb_one(5, 4);
        wb_one(9, 4);
    endtask

    task automatic t_hazards();
        int base, k;
        base = n_iss;
        fill_one(2, 8'h10, 7, 1, 2, 1'b1);
        idle(8);
        check(n_iss == base + 1 && log_dst[base] == 7, "R2 long load issued", n_iss - base, 1);
        fill_one(2, 8'h11, 9, 1, 2, 1'b0);
        idle(8);
        check(n_iss == base + 2 && log_op[base+1] == 8'h11,
              "R11 independent issue under pending load (R5 slot freed)", n_iss - base, 2);
        fill_one(2, 8'h12, 11, 7, 3, 1'b0);
        idle(10);
        check(n_iss == base + 2, "R4 RAW blocked", n_iss - base, 2);
        wb_one(5, 7);
        idle(6);
        check(n_iss == base + 2, "R4 other warp writeback no effect", n_iss - base, 2);
        k = cyc;
        wb_one(2, 7);
        idle(6);
        check(n_iss == base + 3 && log_op[base+2] == 8'h12, "R6 consumer released",
              n_iss - base, 3);
        check(log_cyc[base+2] == k + 1, "R6 no extra delay", log_cyc[base+2] - k, 1);
        fill_one(2, 8'h13, 9, 0, 0, 1'b0);
        idle(10);
        check(n_iss == base + 3, "R4 WAW blocked", n_iss - base, 3);
        wb_one(2, 9);
        idle(6);
        check(n_iss == base + 4 && log_op[base+3] == 8'h13, "R4 WAW released",
              n_iss - base, 4);
        wb_one(2, 9);
        wb_one(2, 11);
    endtask

    task automatic t_set_wins();
        int base, k;
        base = n_iss;
        stall = 1'b1;
        fill_one(1, 8'h20, 10, 0, 0, 1'b0);
        idle(2);
        k = cyc;
        stall    = 1'b0;
        wb_valid = 1'b1;
        wb_warp  = WARP_W'(1);
        wb_reg   = REG_W'(10);
        @(negedge clk);
        wb_valid = 1'b0;
        idle(6);
        check(n_iss == base + 1 && log_cyc[base] == k + 1, "R7 issue at coincident edge",
              n_iss - base, 1);
        fill_one(1, 8'h21, 12, 10, 0, 1'b0);
        idle(10);
        check(n_iss == base + 1, "R7 register stays pending", n_iss - base, 1);
        wb_one(1, 10);
        idle(6);
        check(n_iss == base + 2 && log_op[base+1] == 8'h21, "R7 released by later writeback",
              n_iss - base, 2);
        wb_one(1, 12);
    endtask

    task automatic t_occupied();
        int base;
        base = n_iss;
        stall = 1'b1;
        fill_one(7, 8'h11, 1, 0, 0, 1'b0);
        fill_one(7, 8'h22, 2, 0, 0, 1'b0);
        stall = 1'b0;
        idle(12);
        check(n_iss == base + 1, "R3 second fill dropped", n_iss - base, 1);
        check(log_op[base] == 8'h11, "R3 original kept", log_op[base], 8'h11);
        wb_one(7, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_round_robin();
        t_hazards();
        t_set_wins();
        t_occupied();
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule